// File: doc/BRIEF.md
# Cell Bus Receive Filter and Router

This block sits on the receive side of a shared, slotted cell bus. A cell occupies one frame of `FRAME_WORDS` consecutive 32-bit words. The first word, flagged by `cb_sof`, is the routing header. The block judges each cell against the grant that came with its frame, a 4-bit header checksum, the cell's addressing and a bit-interleaved parity byte carried in the final word. A cell that passes all of them is handed to one of three local consumers: loopback, control or PHY transmit.

The header is checked at frame start. Only a cell that passes that check is written into a single-cell holding store. The parity byte can only be checked once the last word has arrived, so a cell is released only after that check. It then leaves word by word, in arrival order, on the ready/valid stream picked by the header. Three saturating counters record cells dropped for a bad header checksum, for bad parity, and for arriving while the store was still occupied.

Top module: `cbrx_filter_router`

## Requirements
- R1: After reset, no `out_valid` bit is high and all three drop counters read zero.
- R2: A frame whose `cb_grant_ok` is low on its `cb_sof` cycle produces no output and changes no counter, even if the cell is otherwise good.
- R3: The header checksum is computed over header bits 31:4, most significant bit first, with polynomial x^4+x+1 and a zero preset. It must equal header bits 3:0. On a granted frame a mismatch drops the cell and adds one to `crc_drops`.
- R4: Header bits 31:30 give the kind: 00 single, 01 multicast, 10 broadcast, 11 reserved. Bits 8:4 are the address field. A single-address cell is taken only when that field equals `unit_addr`; otherwise it is ignored silently.
- R5: A broadcast cell is taken whatever its address field holds. A multicast cell is taken only when `mc_mask` bit [address field] is 1. A reserved-kind cell is ignored silently.
- R6: Bits 31:24 of the final word must equal the XOR of every other byte of the cell, header included. On a mismatch the cell is dropped, `bip_drops` goes up by one, and nothing is output.
- R7: Header bits 29:28 pick the stream: 00 gives `out_valid[0]` (loopback), 01 gives `out_valid[1]` (control), 10 gives `out_valid[2]` (PHY). A value of 11 means the cell is ignored silently. An accepted cell is first valid in the cycle after its final word. It leaves all `FRAME_WORDS` words in arrival order, with `out_last` on the final word, and at most one stream is valid at a time.
- R8: While the selected `out_ready` bit is low, the output word, `out_last` and `out_valid` hold steady.
- R9: A cell that would be accepted, but whose `cb_sof` falls while a cell is still held, is dropped and adds one to `busy_drops`. This includes the cycle of the held cell's final handshake. The held cell is unaffected.
- R10: A `cb_sof` that arrives before the cell being collected is complete abandons that partial cell, with no output and no count, and the new frame is judged on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cb_word | input | 32 | Bus word of the current cycle |
| cb_sof | input | 1 | Marks the header word of a frame |
| cb_grant_ok | input | 1 | Grant of this frame was valid (sampled with `cb_sof`) |
| unit_addr | input | ADDR_W | Local unit address |
| mc_mask | input | 2**ADDR_W | Multicast groups to accept |
| out_ready | input | 3 | Consumer ready: loopback, control, PHY |
| out_valid | output | 3 | Word valid per stream: loopback, control, PHY |
| out_data | output | 32 | Word of the cell being released |
| out_last | output | 1 | Final word of the cell |
| crc_drops | output | CNT_W | Cells dropped for header checksum |
| bip_drops | output | CNT_W | Cells dropped for parity |
| busy_drops | output | CNT_W | Cells dropped because the store was occupied |

## Verification
Two functions can meet in one clock edge: the last handshake of a held cell draining, and the `cb_sof` of a new acceptable cell. The bench provokes this by sending a cell with all readies high, then launching the next acceptable frame exactly `FRAME_WORDS` cycles after the first cell's final word, which is the edge of the final handshake. A third frame follows one frame later. The behavioural model says the middle frame counts as a busy drop and the third cell comes out whole. Every cycle of that exchange is compared against the model.

// File: rtl/cbrx_pkg.sv
package cbrx_pkg;

   localparam int WORD_W   = 32;
   localparam int NUM_DEST = 3;
   localparam int DEST_W   = 2;

   typedef enum logic [1:0] {
      KIND_SINGLE = 2'b00,
      KIND_MCAST  = 2'b01,
      KIND_BCAST  = 2'b10,
      KIND_RSVD   = 2'b11
   } cell_kind_e;

   typedef enum logic [1:0] {
      DEST_LOOP = 2'b00,
      DEST_CTRL = 2'b01,
      DEST_PHY  = 2'b10,
      DEST_NONE = 2'b11
   } dest_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_FILL = 2'b01,
      ST_HOLD = 2'b10
   } store_st_e;

   localparam int DROP_CRC  = 0;
   localparam int DROP_BIP  = 1;
   localparam int DROP_BUSY = 2;
   localparam int NUM_DROP  = 3;

endpackage

// File: rtl/cbrx_hdr_check.sv
module cbrx_hdr_check
   import cbrx_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic [WORD_W-1:0]    hdr,
   input  logic [ADDR_W-1:0]    unit_addr,
   input  logic [2**ADDR_W-1:0] mc_mask,
   output logic                 crc_ok,
   output logic                 addr_hit,
   output logic                 dest_ok,
   output logic [DEST_W-1:0]    dest
);

   localparam int CRC_W  = 4;
   localparam int BODY_W = WORD_W - CRC_W;

   generate
      if (ADDR_W < 1 || ADDR_W > BODY_W - 4) begin : g_bad_addr_w
         $error("cbrx_hdr_check: ADDR_W out of range");
      end
   endgenerate

   function automatic logic [CRC_W-1:0] crc4_of(input logic [BODY_W-1:0] body);
      logic [CRC_W-1:0] c;
      logic             fb;
      c = '0;
      for (int b = BODY_W - 1; b >= 0; b--) begin
         fb = c[CRC_W-1] ^ body[b];
         c  = {c[CRC_W-2:0], 1'b0};
         if (fb) c = c ^ 4'b0011;
      end
      return c;
   endfunction

   cell_kind_e        kind;
   logic [ADDR_W-1:0] tag;

   assign kind   = cell_kind_e'(hdr[WORD_W-1 -: 2]);
   assign tag    = hdr[CRC_W +: ADDR_W];
   assign crc_ok = (crc4_of(hdr[WORD_W-1:CRC_W]) == hdr[CRC_W-1:0]);
   assign dest   = hdr[WORD_W-3 -: DEST_W];
   assign dest_ok = (dest_e'(dest) != DEST_NONE);

   always_comb begin
      unique case (kind)
         KIND_SINGLE: addr_hit = (tag == unit_addr);
         KIND_MCAST:  addr_hit = mc_mask[tag];
         KIND_BCAST:  addr_hit = 1'b1;
         default:     addr_hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/cbrx_bip_check.sv
module cbrx_bip_check
   import cbrx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic [WORD_W-1:0] word,
   output logic              bip_ok
);

   localparam int NBYTES = WORD_W / 8;

   generate
      if (WORD_W % 8 != 0 || NBYTES < 2) begin : g_bad_word_w
         $error("cbrx_bip_check: word must hold at least two whole bytes");
      end
   endgenerate

   logic [7:0] acc_q;
   logic [7:0] fold_low;
   logic [7:0] fold_all;

   always_comb begin
      fold_low = '0;
      for (int k = 0; k < NBYTES - 1; k++) begin
         fold_low = fold_low ^ word[8*k +: 8];
      end
      fold_all = fold_low ^ word[WORD_W-1 -: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (start) begin
         acc_q <= fold_all;
      end else if (step) begin
         acc_q <= acc_q ^ fold_all;
      end
   end

   assign bip_ok = ((acc_q ^ fold_low) == word[WORD_W-1 -: 8]);

endmodule

// File: rtl/cbrx_cell_store.sv
module cbrx_cell_store
   import cbrx_pkg::*;
#(
   parameter int WORDS = 16,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [WORD_W-1:0] rd_data
);

   logic [WORD_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_data;
   end

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/cbrx_sat_ctr.sv
module cbrx_sat_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);

   generate
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("cbrx_sat_ctr: CNT_W must be positive");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (inc && count != {CNT_W{1'b1}}) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/cbrx_filter_router.sv
module cbrx_filter_router
   import cbrx_pkg::*;
#(
   parameter int FRAME_WORDS = 16,
   parameter int ADDR_W      = 5,
   parameter int CNT_W       = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [WORD_W-1:0]    cb_word,
   input  logic                 cb_sof,
   input  logic                 cb_grant_ok,
   input  logic [ADDR_W-1:0]    unit_addr,
   input  logic [2**ADDR_W-1:0] mc_mask,
   input  logic [NUM_DEST-1:0]  out_ready,
   output logic [NUM_DEST-1:0]  out_valid,
   output logic [WORD_W-1:0]    out_data,
   output logic                 out_last,
   output logic [CNT_W-1:0]     crc_drops,
   output logic [CNT_W-1:0]     bip_drops,
   output logic [CNT_W-1:0]     busy_drops
);

   localparam int            IDX_W    = $clog2(FRAME_WORDS);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);

   generate
      if (FRAME_WORDS < 2) begin : g_bad_frame
         $error("cbrx_filter_router: FRAME_WORDS must be at least 2");
      end
   endgenerate

   store_st_e         st_q;
   logic [IDX_W-1:0]  wr_idx_q;
   logic [IDX_W-1:0]  rd_idx_q;
   logic [DEST_W-1:0] dest_q;

   logic              crc_ok, addr_hit, dest_ok, bip_ok;
   logic [DEST_W-1:0] hdr_dest;

   cbrx_hdr_check #(.ADDR_W(ADDR_W)) u_hdr (
      .hdr       (cb_word),
      .unit_addr (unit_addr),
      .mc_mask   (mc_mask),
      .crc_ok    (crc_ok),
      .addr_hit  (addr_hit),
      .dest_ok   (dest_ok),
      .dest      (hdr_dest)
   );

   logic accept, start_fill, busy_hit, crc_bad;
   logic fill_step, fill_last, bip_bad, drain_fire, drain_done;

   assign accept     = cb_sof & cb_grant_ok & crc_ok & addr_hit & dest_ok;
   assign start_fill = accept & (st_q != ST_HOLD);
   assign busy_hit   = accept & (st_q == ST_HOLD);
   assign crc_bad    = cb_sof & cb_grant_ok & ~crc_ok;
   assign fill_step  = (st_q == ST_FILL) & ~cb_sof;
   assign fill_last  = fill_step & (wr_idx_q == LAST_IDX);
   assign bip_bad    = fill_last & ~bip_ok;
   assign drain_fire = (st_q == ST_HOLD) & out_ready[dest_q];
   assign drain_done = drain_fire & (rd_idx_q == LAST_IDX);

   cbrx_bip_check u_bip (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start_fill),
      .step   (fill_step),
      .word   (cb_word),
      .bip_ok (bip_ok)
   );

   cbrx_cell_store #(.WORDS(FRAME_WORDS)) u_store (
      .clk     (clk),
      .wr_en   (start_fill | fill_step),
      .wr_idx  (start_fill ? '0 : wr_idx_q),
      .wr_data (cb_word),
      .rd_idx  (rd_idx_q),
      .rd_data (out_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         wr_idx_q <= '0;
         rd_idx_q <= '0;
         dest_q   <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_fill) begin
                  st_q     <= ST_FILL;
                  wr_idx_q <= IDX_W'(1);
                  dest_q   <= hdr_dest;
               end
            end
            ST_FILL: begin
               if (cb_sof) begin
                  if (start_fill) begin
                     wr_idx_q <= IDX_W'(1);
                     dest_q   <= hdr_dest;
                  end else begin
                     st_q <= ST_IDLE;
                  end
               end else if (fill_last) begin
                  rd_idx_q <= '0;
                  st_q     <= bip_ok ? ST_HOLD : ST_IDLE;
               end else begin
                  wr_idx_q <= wr_idx_q + 1'b1;
               end
            end
            ST_HOLD: begin
               if (drain_done) begin
                  st_q <= ST_IDLE;
               end else if (drain_fire) begin
                  rd_idx_q <= rd_idx_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   generate
      for (genvar d = 0; d < NUM_DEST; d++) begin : g_stream
         assign out_valid[d] = (st_q == ST_HOLD) && (dest_q == DEST_W'(d));
      end
   endgenerate

   assign out_last = (st_q == ST_HOLD) && (rd_idx_q == LAST_IDX);

   logic [NUM_DROP-1:0] drop_evt;
   logic [CNT_W-1:0]    drop_cnt [NUM_DROP];

   assign drop_evt[DROP_CRC]  = crc_bad;
   assign drop_evt[DROP_BIP]  = bip_bad;
   assign drop_evt[DROP_BUSY] = busy_hit;

   generate
      for (genvar k = 0; k < NUM_DROP; k++) begin : g_drop
         cbrx_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (drop_evt[k]),
            .count (drop_cnt[k])
         );
      end
   endgenerate

   assign crc_drops  = drop_cnt[DROP_CRC];
   assign bip_drops  = drop_cnt[DROP_BIP];
   assign busy_drops = drop_cnt[DROP_BUSY];

endmodule

// File: rtl/cbrx_filter_router_chk.sv
module cbrx_filter_router_chk #(
   parameter int CNT_W    = 16,
   parameter int NUM_DEST = 3,
   parameter int WORD_W   = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cb_sof,
   input logic                cb_grant_ok,
   input logic [NUM_DEST-1:0] out_valid,
   input logic [NUM_DEST-1:0] out_ready,
   input logic [WORD_W-1:0]   out_data,
   input logic                out_last,
   input logic [CNT_W-1:0]    crc_drops,
   input logic [CNT_W-1:0]    bip_drops,
   input logic [CNT_W-1:0]    busy_drops
);

   assert_one_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid));

   assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(out_valid & ~out_ready)) |=>
         ($stable(out_valid) && $stable(out_data) && $stable(out_last)));

   assert_crc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_drops == $past(crc_drops)) || (crc_drops == CNT_W'($past(crc_drops) + 1'b1)));

   assert_bip_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bip_drops == $past(bip_drops)) || (bip_drops == CNT_W'($past(bip_drops) + 1'b1)));

   assert_busy_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_drops == $past(busy_drops)) || (busy_drops == CNT_W'($past(busy_drops) + 1'b1)));

   assert_no_grant_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cb_sof && !cb_grant_ok) |=>
         ($stable(crc_drops) && $stable(bip_drops) && $stable(busy_drops) && !$rose(|out_valid)));

endmodule

bind cbrx_filter_router cbrx_filter_router_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cb_sof      (cb_sof),
   .cb_grant_ok (cb_grant_ok),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_data    (out_data),
   .out_last    (out_last),
   .crc_drops   (crc_drops),
   .bip_drops   (bip_drops),
   .busy_drops  (busy_drops)
);

// File: tb/cbrx_filter_router_tb.sv
`timescale 1ns/1ps
module cbrx_filter_router_tb;

   localparam int FW = 16;
   localparam int AW = 5;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   cb_word = '0;
   logic          cb_sof = 1'b0;
   logic          cb_grant_ok = 1'b0;
   logic [AW-1:0] unit_addr = 5'd19;
   logic [31:0]   mc_mask = 32'h0000_0480;
   logic [2:0]    rdy = 3'b111;
   logic [2:0]    out_valid;
   logic [31:0]   out_data;
   logic          out_last;
   logic [CW-1:0] crc_drops, bip_drops, busy_drops;

   always #2 clk = ~clk;

   cbrx_filter_router #(.FRAME_WORDS(FW), .ADDR_W(AW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cb_word(cb_word), .cb_sof(cb_sof),
      .cb_grant_ok(cb_grant_ok), .unit_addr(unit_addr), .mc_mask(mc_mask),
      .out_ready(rdy), .out_valid(out_valid), .out_data(out_data),
      .out_last(out_last), .crc_drops(crc_drops), .bip_drops(bip_drops),
      .busy_drops(busy_drops)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   // ---------------- reference helpers ----------------
   function automatic logic [3:0] ref_crc(input logic [31:0] h);
      logic [31:0] v;
      v = {h[31:4], 4'b0000};
      for (int i = 31; i >= 4; i--) begin
         if (v[i]) v = v ^ (32'h13 << (i - 4));
      end
      return v[3:0];
   endfunction

   function automatic logic [31:0] mk_hdr(input int kind, input int dst, input int addr,
                                          input int filler, input bit bad_crc);
      logic [31:0] h;
      h = {kind[1:0], dst[1:0], filler[18:0], addr[4:0], 4'b0000};
      h[3:0] = ref_crc(h);
      if (bad_crc) h[0] = ~h[0];
      return h;
   endfunction

   // ---------------- behavioural model ----------------
   logic [31:0] m_cap[$];
   logic [31:0] m_hold[$];
   bit          m_fill;
   int          m_dest, m_pend;
   int          m_crc, m_bip, m_busy;
   int          hs [3];

   function automatic bit m_accept(input logic [31:0] h);
      int kind, dst, tag;
      bit hit;
      kind = int'(h[31:30]); dst = int'(h[29:28]); tag = int'(h[8:4]);
      case (kind)
         0: hit = (tag == int'(unit_addr));
         1: hit = mc_mask[tag];
         2: hit = 1'b1;
         default: hit = 1'b0;
      endcase
      return hit && (dst != 3) && (ref_crc(h) == h[3:0]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cap.delete(); m_hold.delete();
         m_fill = 0; m_dest = 0; m_pend = 0;
         m_crc = 0; m_bip = 0; m_busy = 0;
      end else begin
         bit holding, pop;
         holding = (m_hold.size() > 0);
         pop = holding && rdy[m_dest];
         for (int d = 0; d < 3; d++) if (out_valid[d] && rdy[d]) hs[d]++;
         if (cb_sof) begin
            if (cb_grant_ok && m_accept(cb_word)) begin
               if (holding) m_busy++;
               else begin
                  m_cap.delete(); m_cap.push_back(cb_word);
                  m_fill = 1; m_pend = int'(cb_word[29:28]);
               end
            end else begin
               if (cb_grant_ok && ref_crc(cb_word) != cb_word[3:0]) m_crc++;
               m_fill = 0;
            end
         end else if (m_fill) begin
            m_cap.push_back(cb_word);
            if (m_cap.size() == FW) begin
               logic [7:0] x;
               x = '0;
               for (int i = 0; i < FW; i++)
                  for (int j = 0; j < 4; j++)
                     if (!(i == FW - 1 && j == 3)) x = x ^ m_cap[i][8*j +: 8];
               if (x == m_cap[FW-1][31:24]) begin
                  m_hold = m_cap; m_dest = m_pend;
               end else m_bip++;
               m_fill = 0;
            end
         end
         if (pop) void'(m_hold.pop_front());
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [2:0]  ev;
         logic        el;
         logic [31:0] ed;
         bit          bad;
         ev = '0; el = 1'b0; ed = out_data;
         if (m_hold.size() > 0) begin
            ev[m_dest] = 1'b1; el = (m_hold.size() == 1); ed = m_hold[0];
         end
         bad = (out_valid !== ev) || (out_last !== el) || (out_data !== ed) ||
               (int'(crc_drops) != m_crc) || (int'(bip_drops) != m_bip) ||
               (int'(busy_drops) != m_busy);
         checks++;
         if (bad) begin
            errors++;
            $display("FAIL %s cycle: valid %b/%b last %b/%b data %h/%h crc %0d/%0d bip %0d/%0d busy %0d/%0d (actual/expected)",
                     cur_req, out_valid, ev, out_last, el, out_data, ed,
                     crc_drops, m_crc, bip_drops, m_bip, busy_drops, m_busy);
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] w, input bit s, input bit g);
      cb_word = w; cb_sof = s; cb_grant_ok = g;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) drive(32'hA5A5_0000 + 32'(i), 1'b0, 1'b0);
   endtask

   task automatic send(input logic [31:0] hdr, input int seed, input bit bad_bip,
                       input bit grant, input int nwords);
      logic [31:0] w [FW];
      logic [7:0]  x;
      w[0] = hdr;
      for (int i = 1; i < FW; i++) w[i] = 32'(seed) * 32'h9E37_79B1 + 32'(i) * 32'h0101_0107;
      x = '0;
      for (int i = 0; i < FW; i++)
         for (int j = 0; j < 4; j++)
            if (!(i == FW - 1 && j == 3)) x = x ^ w[i][8*j +: 8];
      w[FW-1][31:24] = bad_bip ? ~x : x;
      for (int i = 0; i < nwords; i++) drive(w[i], i == 0, grant);
   endtask

   task automatic clr_hs();
      for (int d = 0; d < 3; d++) hs[d] = 0;
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      clr_hs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      cur_req = "R1";
      chk(out_valid == 3'b000, "R1 valid", int'(out_valid), 0);
      chk(crc_drops == 0 && bip_drops == 0 && busy_drops == 0, "R1 counters",
          int'(crc_drops + bip_drops + busy_drops), 0);

      // R4 single address match, loopback
      cur_req = "R4"; clr_hs();
      send(mk_hdr(0, 0, 19, 123, 0), 1, 0, 1, FW); idle(2*FW);
      chk(hs[0] == FW, "R4 match delivered", hs[0], FW);
      clr_hs();
      send(mk_hdr(0, 0, 18, 5, 0), 2, 0, 1, FW); idle(2*FW);
      chk(hs[0] + hs[1] + hs[2] == 0, "R4 mismatch ignored", hs[0] + hs[1] + hs[2], 0);

      // R5 broadcast / multicast / reserved
      cur_req = "R5"; clr_hs();
      send(mk_hdr(2, 1, 3, 77, 0), 3, 0, 1, FW); idle(2*FW);
      chk(hs[1] == FW, "R5 broadcast to control", hs[1], FW);
      clr_hs();
      send(mk_hdr(1, 2, 7, 9, 0), 4, 0, 1, FW); idle(2*FW);
      chk(hs[2] == FW, "R5 multicast enabled group", hs[2], FW);
      clr_hs();
      send(mk_hdr(1, 2, 9, 9, 0), 5, 0, 1, FW); idle(2*FW);
      send(mk_hdr(3, 0, 19, 9, 0), 6, 0, 1, FW); idle(2*FW);
      chk(hs[0] + hs[1] + hs[2] == 0, "R5 disabled group and reserved kind", hs[0] + hs[1] + hs[2], 0);

      // R2 grant invalid
      cur_req = "R2"; clr_hs();
      send(mk_hdr(0, 0, 19, 1, 0), 7, 0, 0, FW); idle(2*FW);
      send(mk_hdr(0, 0, 19, 1, 1), 8, 0, 0, FW); idle(2*FW);
      chk(hs[0] + hs[1] + hs[2] == 0, "R2 no output", hs[0] + hs[1] + hs[2], 0);
      chk(crc_drops == 0, "R2 crc count untouched", int'(crc_drops), 0);

      // R3 bad header checksum
      cur_req = "R3"; clr_hs();
      send(mk_hdr(2, 0, 1, 44, 1), 9, 0, 1, FW); idle(2*FW);
      chk(crc_drops == 1, "R3 crc drop counted", int'(crc_drops), 1);
      chk(hs[0] == 0, "R3 no output", hs[0], 0);

      // R6 bad parity
      cur_req = "R6"; clr_hs();
      send(mk_hdr(0, 2, 19, 3, 0), 10, 1, 1, FW); idle(2*FW);
      chk(bip_drops == 1, "R6 bip drop counted", int'(bip_drops), 1);
      chk(hs[2] == 0, "R6 no output", hs[2], 0);

      // R7 destination selector 11 ignored
      cur_req = "R7"; clr_hs();
      send(mk_hdr(2, 3, 0, 3, 0), 11, 0, 1, FW); idle(2*FW);
      chk(hs[0] + hs[1] + hs[2] == 0, "R7 selector 11 ignored", hs[0] + hs[1] + hs[2], 0);

      // R8 stall and ready toggling
      cur_req = "R8"; clr_hs(); rdy = 3'b000;
      send(mk_hdr(0, 1, 19, 55, 0), 12, 0, 1, FW); idle(10);
      chk(out_valid == 3'b010, "R8 held under stall", int'(out_valid), 2);
      for (int i = 0; i < 4*FW; i++) begin
         rdy = (i % 3 == 0) ? 3'b010 : 3'b101;
         idle(1);
      end
      rdy = 3'b111; idle(FW);
      chk(hs[1] == FW, "R8 all words delivered", hs[1], FW);

      // R9 acceptable frame on the final drain handshake edge
      cur_req = "R9"; clr_hs();
      send(mk_hdr(0, 0, 19, 2, 0), 13, 0, 1, FW);
      idle(FW - 1);
      send(mk_hdr(2, 1, 0, 2, 0), 14, 0, 1, FW);
      send(mk_hdr(2, 2, 0, 2, 0), 15, 0, 1, FW);
      idle(2*FW);
      chk(busy_drops == 1, "R9 busy drop", int'(busy_drops), 1);
      chk(hs[0] == FW && hs[1] == 0 && hs[2] == FW, "R9 held and later cells intact",
          hs[0] * 100 + hs[1] * 10 + hs[2], FW * 100 + FW);

      // R10 truncated frame followed by a full one
      cur_req = "R10"; clr_hs();
      send(mk_hdr(0, 0, 19, 8, 0), 16, 0, 1, 5);
      send(mk_hdr(0, 2, 19, 8, 0), 17, 0, 1, FW); idle(2*FW);
      chk(hs[0] == 0 && hs[2] == FW, "R10 partial abandoned", hs[0] * 100 + hs[2], FW);
      chk(crc_drops == 1 && bip_drops == 1, "R10 no extra counts",
          int'(crc_drops + bip_drops), 2);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule